// File: doc/BRIEF.md
# Serial Command Engine with Command/Results Store

The block links the chip's internal word-wide register bus to one serial command line and one serial return line that control downstream devices. Software works in one of two ways. For an outgoing command it places the words in a small word store and then writes a word count to a length register. For a query it writes a query word to a dedicated register, which starts the engine. The engine sends bits one per clock, least significant bit first, and keeps a qualifier high while each bit is on the line. For a query it then listens to the return line for a fixed number of cycles and packs those bits into words in the same store. Software reads them back from there.

The engine does not interpret any bit. The layout of a command (marker bits, target, direction, designator, length, arguments) is kept exactly as software places it in the store or the query registers. A status register lets software poll for completion. A second query register can be armed to add 32 more command bits to the next query.

Top module: `ser_cmd_engine`

## Requirements
- R1: After reset the engine is idle, ser_vld_o and ser_listen_o are low, bus_rdata_o is zero and the length and query registers read zero.
- R2: A bus write of N (1..DEPTH) to word address DEPTH (length) while idle sends store words 0..N-1 in order, each LSB first, one bit per cycle with no gaps; ser_vld_o is high from the cycle after the write for exactly 32*N cycles.
- R3: A length write of 0 starts nothing; a length above DEPTH is clamped to DEPTH.
- R4: Word address DEPTH+3 reads 0xFFFFFFFF while idle and 0x00000000 while busy; all bus reads return data in the cycle after the read strobe.
- R5: A bus write to word address DEPTH+1 while idle sends that word LSB first (32 bits); if word address DEPTH+2 was written since the previous query start, its 32 bits follow, and that arming is then cleared.
- R6: After the last command bit of a query, ser_listen_o is high for RET_BITS cycles and ser_ret_i is sampled in each of them; bit k is stored at store word k/32, bit k%32.
- R7: In the last returned word, the bits above the last captured one are written as zero.
- R8: Writes to addresses DEPTH, DEPTH+1 or DEPTH+2 while busy are ignored: they neither restart the engine nor change the value read back.
- R9: Store words 0..DEPTH-1 can be written and read over the bus; DEPTH reads the last accepted count, DEPTH+1 and DEPTH+2 read the last accepted query words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| ser_cmd_o | output | 1 | Serial command bit |
| ser_vld_o | output | 1 | Command bit valid |
| ser_ret_i | input | 1 | Serial return bit |
| ser_listen_o | output | 1 | Return line being sampled |

## Verification
The bench targets the word-boundary hand-off during a multi-word send. A design that reloads one cycle late drops or repeats a bit, or leaves a gap in ser_vld_o. It also checks clamping of an oversized count and the ignored zero count: a faulty design runs past the store or hangs in the busy state. The return path is checked with a count that is not a multiple of 32. This exposes unpadded stale bits and a capture window that is off by one. Start writes issued while the engine is busy test that a design which restarts or re-arms the extension word is caught, through the serial stream it produces and the values it reads back.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/ser_cmd_ram.sv
module ser_cmd_ram #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [IDX_W-1:0] eng_raddr_i,
  output logic [31:0]      eng_rdata_o,
  input  logic             eng_we_i,
  input  logic [IDX_W-1:0] eng_waddr_i,
  input  logic [31:0]      eng_wdata_i
);
  logic [31:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    // engine port wins on a same-word collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (eng_we_i && eng_waddr_i == IDX_W'(g)) mem[g] <= eng_wdata_i;
      else if (bus_we_i && bus_addr_i == IDX_W'(g)) mem[g] <= bus_wdata_i;
    end
  end

  assign bus_rdata_o = mem[bus_addr_i];
  assign eng_rdata_o = mem[eng_raddr_i];
endmodule

// File: rtl/ser_cmd_regs.sv
module ser_cmd_regs #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              busy_i,
  output logic              ram_we_o,
  output logic [IDX_W-1:0]  ram_addr_o,
  input  logic [31:0]       ram_rdata_i,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic [IDX_W-1:0]  start_last_o,
  output logic              start_ext_o,
  output logic [31:0]       cmd_lo_o,
  output logic [31:0]       cmd_hi_o
);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(DEPTH + 2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(DEPTH + 3);

  logic [CNT_W-1:0] len_q, cnt_c;
  logic [31:0]      lo_q, hi_q;
  logic             ext_q;
  logic             in_ram, wr_len, wr_lo, wr_hi;

  assign in_ram = bus_addr_i < ADDR_W'(DEPTH);
  assign wr_len = bus_wr_i && bus_addr_i == A_LEN;
  assign wr_lo  = bus_wr_i && bus_addr_i == A_LO;
  assign wr_hi  = bus_wr_i && bus_addr_i == A_HI;

  assign ram_we_o   = bus_wr_i && in_ram;
  assign ram_addr_o = bus_addr_i[IDX_W-1:0];

  assign cnt_c = (bus_wdata_i > 32'(DEPTH)) ? CNT_W'(DEPTH) : bus_wdata_i[CNT_W-1:0];

  assign start_wr_o   = wr_len && !busy_i && (bus_wdata_i != '0);
  assign start_rd_o   = wr_lo && !busy_i;
  assign start_last_o = IDX_W'(cnt_c - CNT_W'(1));
  assign start_ext_o  = ext_q;
  // query word is loaded on the same edge it is written
  assign cmd_lo_o     = start_rd_o ? bus_wdata_i : lo_q;
  assign cmd_hi_o     = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      if (start_wr_o) len_q <= cnt_c;
      if (start_rd_o) begin
        lo_q  <= bus_wdata_i;
        ext_q <= 1'b0;
      end
      if (wr_hi && !busy_i) begin
        hi_q  <= bus_wdata_i;
        ext_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      if (in_ram)                    bus_rdata_o <= ram_rdata_i;
      else if (bus_addr_i == A_LEN)  bus_rdata_o <= 32'(len_q);
      else if (bus_addr_i == A_LO)   bus_rdata_o <= lo_q;
      else if (bus_addr_i == A_HI)   bus_rdata_o <= hi_q;
      else if (bus_addr_i == A_STAT) bus_rdata_o <= busy_i ? 32'h0 : 32'hFFFF_FFFF;
      else                           bus_rdata_o <= '0;
    end
  end

  // R4
  stat_busy_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == A_STAT && busy_i) |=> bus_rdata_o == 32'h0);
  // R8
  lo_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_lo) |=> $stable(lo_q));
  // R3
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_len && !busy_i && bus_wdata_i == '0) |=> !busy_i);
endmodule

// File: rtl/ser_cmd_fsm.sv
module ser_cmd_fsm
  import ser_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int RET_BITS = 40,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CAP_W   = $clog2(RET_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_wr_i,
  input  logic             start_rd_i,
  input  logic [IDX_W-1:0] start_last_i,
  input  logic             start_ext_i,
  input  logic [31:0]      cmd_lo_i,
  input  logic [31:0]      cmd_hi_i,
  output logic [IDX_W-1:0] ram_raddr_o,
  input  logic [31:0]      ram_rdata_i,
  output logic             ram_we_o,
  output logic [IDX_W-1:0] ram_waddr_o,
  output logic [31:0]      ram_wdata_o,
  input  logic             ser_ret_i,
  output logic             ser_cmd_o,
  output logic             ser_vld_o,
  output logic             ser_listen_o,
  output logic             busy_o
);
  eng_state_e       state_q;
  logic [31:0]      sreg_q, load_word, cap_word_q, cap_merge;
  logic [4:0]       bit_q, cap_pos_q;
  logic [IDX_W-1:0] word_q, last_q, ret_idx_q;
  logic             rd_mode_q, use_reg, cap_last;
  logic [CAP_W-1:0] cap_cnt_q;

  // 2:1 word source select: store word or query register
  assign use_reg     = (state_q == ST_IDLE) ? start_rd_i : rd_mode_q;
  assign ram_raddr_o = (state_q == ST_IDLE) ? '0 : word_q + IDX_W'(1);
  assign load_word   = !use_reg ? ram_rdata_i :
                       (state_q == ST_IDLE) ? cmd_lo_i : cmd_hi_i;

  assign cap_merge   = cap_word_q | (32'(ser_ret_i) << cap_pos_q);
  assign cap_last    = cap_cnt_q == CAP_W'(RET_BITS - 1);
  assign ram_we_o    = (state_q == ST_CAP) && (cap_pos_q == 5'd31 || cap_last);
  assign ram_waddr_o = ret_idx_q;
  assign ram_wdata_o = cap_merge;

  assign ser_cmd_o    = sreg_q[0];
  assign ser_vld_o    = state_q == ST_SHIFT;
  assign ser_listen_o = state_q == ST_CAP;
  assign busy_o       = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sreg_q     <= '0;
      bit_q      <= '0;
      word_q     <= '0;
      last_q     <= '0;
      rd_mode_q  <= 1'b0;
      cap_word_q <= '0;
      cap_pos_q  <= '0;
      ret_idx_q  <= '0;
      cap_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_wr_i || start_rd_i) begin
            state_q   <= ST_SHIFT;
            sreg_q    <= load_word;
            bit_q     <= '0;
            word_q    <= '0;
            last_q    <= start_rd_i ? IDX_W'(start_ext_i) : start_last_i;
            rd_mode_q <= start_rd_i;
          end
        end
        ST_SHIFT: begin
          bit_q <= bit_q + 5'd1;
          if (bit_q == 5'd31) begin
            if (word_q == last_q) begin
              sreg_q     <= '0;
              cap_word_q <= '0;
              cap_pos_q  <= '0;
              ret_idx_q  <= '0;
              cap_cnt_q  <= '0;
              state_q    <= rd_mode_q ? ST_CAP : ST_IDLE;
            end else begin
              word_q <= word_q + IDX_W'(1);
              sreg_q <= load_word;
            end
          end else begin
            sreg_q <= sreg_q >> 1;
          end
        end
        ST_CAP: begin
          cap_word_q <= ram_we_o ? '0 : cap_merge;
          cap_pos_q  <= cap_pos_q + 5'd1;
          cap_cnt_q  <= cap_cnt_q + CAP_W'(1);
          if (cap_pos_q == 5'd31) ret_idx_q <= ret_idx_q + IDX_W'(1);
          if (cap_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  start_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i || start_rd_i) |-> state_q == ST_IDLE);
  // R2
  vld_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_vld_o) |-> $past(start_wr_i || start_rd_i));
  // R6
  listen_after_query_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ser_vld_o) && rd_mode_q) |-> ser_listen_o);
  // R7
  final_word_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_listen_o) |-> $past(ram_we_o));
endmodule

// File: rtl/ser_cmd_engine.sv
module ser_cmd_engine #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 6,
  parameter int RET_BITS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              ser_cmd_o,
  output logic              ser_vld_o,
  input  logic              ser_ret_i,
  output logic              ser_listen_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             busy, bus_we, start_wr, start_rd, start_ext, eng_we;
  logic [IDX_W-1:0] bus_ram_addr, start_last, eng_raddr, eng_waddr;
  logic [31:0]      bus_ram_rdata, eng_rdata, eng_wdata, cmd_lo, cmd_hi;

  ser_cmd_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_wdata_i, .bus_rdata_o,
    .busy_i       (busy),
    .ram_we_o     (bus_we),
    .ram_addr_o   (bus_ram_addr),
    .ram_rdata_i  (bus_ram_rdata),
    .start_wr_o   (start_wr),
    .start_rd_o   (start_rd),
    .start_last_o (start_last),
    .start_ext_o  (start_ext),
    .cmd_lo_o     (cmd_lo),
    .cmd_hi_o     (cmd_hi)
  );

  ser_cmd_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i, .rst_ni,
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_ram_addr),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_ram_rdata),
    .eng_raddr_i (eng_raddr),
    .eng_rdata_o (eng_rdata),
    .eng_we_i    (eng_we),
    .eng_waddr_i (eng_waddr),
    .eng_wdata_i (eng_wdata)
  );

  ser_cmd_fsm #(.DEPTH(DEPTH), .RET_BITS(RET_BITS)) u_fsm (
    .clk_i, .rst_ni,
    .start_wr_i   (start_wr),
    .start_rd_i   (start_rd),
    .start_last_i (start_last),
    .start_ext_i  (start_ext),
    .cmd_lo_i     (cmd_lo),
    .cmd_hi_i     (cmd_hi),
    .ram_raddr_o  (eng_raddr),
    .ram_rdata_i  (eng_rdata),
    .ram_we_o     (eng_we),
    .ram_waddr_o  (eng_waddr),
    .ram_wdata_o  (eng_wdata),
    .ser_ret_i, .ser_cmd_o, .ser_vld_o, .ser_listen_o,
    .busy_o       (busy)
  );
endmodule

// File: tb/ser_cmd_engine_bench.sv
module ser_cmd_engine_bench;
  localparam int CLK_P    = 10;
  localparam int DEPTH    = 16;
  localparam int ADDR_W   = 6;
  localparam int RET_BITS = 40;
  localparam int A_LEN = DEPTH, A_LO = DEPTH + 1, A_HI = DEPTH + 2, A_STAT = DEPTH + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, ret = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic cmd, vld, listen;

  int n_chk = 0, n_err = 0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  ser_cmd_engine #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RET_BITS(RET_BITS)) u_ser_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ser_cmd_o(cmd), .ser_vld_o(vld),
    .ser_ret_i(ret), .ser_listen_o(listen)
  );

  // behavioural reference model
  logic [31:0] mram [DEPTH];
  bit   q [$];
  int   cap_rem = 0, cap_k = 0;
  logic [31:0] m_len = '0, m_lo = '0, m_hi = '0, exp_rd = '0;
  bit   m_ext = 0, m_rdmode = 0, rd_pend = 0;

  function automatic bit m_busy();
    return q.size() > 0 || cap_rem > 0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a < DEPTH)       return mram[a];
    if (a == A_LEN)      return m_len;
    if (a == A_LO)       return m_lo;
    if (a == A_HI)       return m_hi;
    if (a == A_STAT)     return m_busy() ? 32'h0 : 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  task automatic push_word(logic [31:0] w);
    for (int i = 0; i < 32; i++) q.push_back(w[i]);
  endtask

  initial for (int i = 0; i < DEPTH; i++) mram[i] = '0;

  always @(posedge clk) if (rst_n) begin
    bit busy_pre;
    busy_pre = m_busy();
    rd_pend = rd;
    if (rd) exp_rd = m_read(int'(addr));
    if (q.size() > 0) begin
      void'(q.pop_front());
      if (q.size() == 0 && m_rdmode) begin cap_rem = RET_BITS; cap_k = 0; end
    end else if (cap_rem > 0) begin
      if (cap_k % 32 == 0) mram[cap_k/32] = '0;
      mram[cap_k/32][cap_k%32] = ret;
      cap_k++; cap_rem--;
    end
    if (wr) begin
      if (int'(addr) < DEPTH) mram[addr] = wdata;
      else if (!busy_pre && int'(addr) == A_LEN && wdata != 0) begin
        m_len = (wdata > DEPTH) ? DEPTH : wdata;
        m_rdmode = 0;
        for (int i = 0; i < int'(m_len); i++) push_word(mram[i]);
      end else if (!busy_pre && int'(addr) == A_LO) begin
        m_lo = wdata; m_rdmode = 1;
        push_word(wdata);
        if (m_ext) push_word(m_hi);
        m_ext = 0;
      end else if (!busy_pre && int'(addr) == A_HI) begin
        m_hi = wdata; m_ext = 1;
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    chk(tag, 32'(vld), 32'(q.size() > 0));
    if (q.size() > 0) chk(tag, 32'(cmd), 32'(q[0]));
    chk(tag, 32'(listen), 32'(cap_rem > 0));
    if (rd_pend) chk(tag, rdata, exp_rd);
  end

  logic [31:0] cyc = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ret <= cyc[0] ^ cyc[3] ^ cyc[4] ^ cyc[6];
  end

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy()) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2 watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    chk("R1", rdata, 32'h0);
    chk("R1", 32'(vld), 32'h0);
    bus_rd(A_STAT, v); chk("R1", v, 32'hFFFF_FFFF);
    bus_rd(A_LEN, v);  chk("R1", v, 32'h0);
    // R9 store access
    tag = "R9";
    for (int i = 0; i < DEPTH; i++) bus_wr(i, 32'hA5C3_0000 ^ (32'(i) * 32'h0101_7F13));
    bus_rd(5, v); chk("R9", v, 32'hA5C3_0000 ^ (32'd5 * 32'h0101_7F13));
    // R2 three-word send, with busy status and ignored restarts
    tag = "R2";
    bus_wr(A_LEN, 32'd3);
    repeat (5) @(negedge clk);
    tag = "R4";
    bus_rd(A_STAT, v); chk("R4", v, 32'h0);
    tag = "R8";
    bus_wr(A_LEN, 32'd7);
    bus_wr(A_LO, 32'hDEAD_BEEF);
    bus_wr(A_HI, 32'h1234_5678);
    tag = "R2";
    wait_idle();
    bus_rd(A_STAT, v); chk("R4", v, 32'hFFFF_FFFF);
    bus_rd(A_LEN, v);  chk("R8", v, 32'd3);
    bus_rd(A_LO, v);   chk("R8", v, 32'h0);
    bus_rd(A_HI, v);   chk("R8", v, 32'h0);
    // R3 zero count, then clamp
    tag = "R3";
    bus_wr(A_LEN, 32'd0);
    repeat (3) @(negedge clk);
    chk("R3", 32'(vld), 32'h0);
    bus_rd(A_STAT, v); chk("R3", v, 32'hFFFF_FFFF);
    bus_wr(A_LEN, 32'd100);
    wait_idle();
    bus_rd(A_LEN, v); chk("R3", v, 32'(DEPTH));
    // R5 single-word query, R6/R7 capture and padding
    tag = "R5";
    for (int i = 0; i < 3; i++) bus_wr(i, 32'hFFFF_FFFF);
    bus_wr(A_LO, 32'h8000_0001);
    tag = "R6";
    wait_idle();
    bus_rd(1, v); chk("R7", v & 32'hFFFF_FF00, 32'h0);
    bus_rd(2, v); chk("R6", v, 32'hFFFF_FFFF);
    bus_rd(0, v);
    // R5 two-word query with arming
    tag = "R5";
    bus_wr(A_HI, 32'h0F0F_3C3C);
    bus_wr(A_LO, 32'h1357_9BDF);
    repeat (40) @(negedge clk);
    tag = "R8";
    bus_wr(A_HI, 32'h7777_7777);
    tag = "R6";
    wait_idle();
    bus_rd(A_HI, v); chk("R9", v, 32'h0F0F_3C3C);
    bus_rd(A_LO, v); chk("R9", v, 32'h1357_9BDF);
    // arming cleared: next query is one word only
    tag = "R5";
    bus_wr(A_LO, 32'h0000_00F1);
    wait_idle();
    bus_rd(0, v);
    bus_rd(1, v);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule